// File: doc/BRIEF.md
# Asynchronous Queue-Head Ring Walker

This block steps a host controller through the circular list of queue heads that carries control and bulk traffic. Software loads a list address and sets an enable bit. On the cycle after each microframe-start strobe, the walker opens a service window. It fetches the horizontal link word of the queue head at the list address and marks that queue head as serviced. It then follows the link to the next entry and repeats, until something ends the window.

A window ends on whichever comes first: a microframe-end strobe, an empty-list indication, or a disable that takes effect. When it ends, the link pointer of the last queue head fetched is written back into the list address register, so the next window starts there. This gives round-robin fairness over the ring. The enable bit is only looked at when the walker is about to fetch. A status bit follows it at that point, so software can see when a change has taken effect. Link words that carry a non-queue-head type stop the window and raise an error pulse.

Top module: `async_sched_walker`

## Requirements
- R1: After reset the status bit, the fetch request, the service strobe and the error pulse are all low.
- R2: While the enable bit is clear, a microframe-start strobe causes no fetch request, and the status bit stays low.
- R3: The first fetch of a window goes to the address held in the list address register. That window opens on the cycle after a microframe-start strobe.
- R4: Each accepted link word of queue-head type gives a one-cycle service strobe carrying the fetched entry's address. The next fetch goes to the link word with its low 5 bits cleared, wrapping around the ring without end.
- R5: A microframe-end strobe, even while a fetch is outstanding, lets that fetch complete, then ends the window. The list address register then holds the last fetched entry's link pointer, and the next window's first fetch goes there.
- R6: If the empty-list input is high at a fetch point, no fetch is issued and the window ends, with the pointer retained as in R5.
- R7: A change of the enable bit is sampled only at a fetch point, meaning a window start or the return of a link word. The status bit updates there. When the enable is clear, the window ends.
- R8: A write to the list address register takes effect only while both the enable bit and the status bit are clear. Otherwise it is ignored.
- R9: The entry type sits in link-word bits [2:1], where 01 means queue head. Any other value gives a one-cycle error pulse and no service strobe, ends the window, and leaves the list address unchanged.
- R10: Link-word bit 0, the terminate flag, has no effect: the pointer is followed anyway.
- R11: While a fetch request waits for ready, its address stays stable.
- R12: Every fetch address has its low 5 bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Software enable bit |
| addr_wr_en | input | 1 | List address write strobe |
| addr_wr_data | input | 32 | List address write value |
| uframe_start | input | 1 | Microframe-start strobe |
| uframe_end | input | 1 | Microframe-end strobe |
| list_empty | input | 1 | Empty-list indication |
| rd_req_valid | output | 1 | Link fetch request valid |
| rd_req_ready | input | 1 | Link fetch request accepted |
| rd_req_addr | output | 32 | Queue-head address to fetch |
| rd_rsp_valid | input | 1 | Link word returned |
| rd_rsp_data | input | 32 | Horizontal link word |
| sched_active | output | 1 | Status bit mirroring the sampled enable |
| list_addr | output | 32 | List address register |
| svc_valid | output | 1 | Queue head serviced strobe |
| svc_addr | output | 32 | Address of the serviced queue head |
| type_err | output | 1 | Non-queue-head entry detected |

## Verification
The bench walks a four-entry ring whose third entry has its terminate flag set. A walker that obeys that flag stops early instead of wrapping. Fetches are stalled on alternate cycles, so a design that drops or repeats a fetch under backpressure produces a broken address sequence. Windows are ended in three ways: by a microframe-end strobe during traffic, by the empty-list input, and by clearing the enable. Each time, the retained pointer and the first fetch of the following window are compared against the ring model. A design that saves the current entry instead of its link, or that restarts from the originally written address, fails there. The bench also clears the enable while the walker is idle, checks that the status bit holds until the next window start, and checks that address writes are refused meanwhile. Finally, an entry typed as isochronous must raise an error without producing a service strobe.

// File: rtl/asw_pkg.sv
package asw_pkg;
  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_REQ  = 2'd1,
    WK_WAIT = 2'd2
  } walk_st_e;

  localparam int          LINK_TYPE_LSB = 1;
  localparam int          LINK_TYPE_W   = 2;
  localparam logic [1:0]  LINK_TYPE_QH  = 2'b01;
endpackage

// File: rtl/asw_rst_sync.sv
module asw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/asw_list_reg.sv
module asw_list_reg #(
  parameter int AW = 32,
  parameter int AL = 5
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          cfg_en,
  input  logic          sts,
  input  logic          commit,
  input  logic [AW-1:0] commit_addr,
  output logic [AW-1:0] list_addr
);
  localparam int HW = AW - AL;

  logic [HW-1:0] base_q;
  logic [HW-1:0] base_d;
  logic          base_ce;
  logic          wr_ok;

  assign wr_ok = wr_en && !cfg_en && !sts;

  always_comb begin
    base_ce = 1'b0;
    base_d  = base_q;
    if (commit) begin
      base_ce = 1'b1;
      base_d  = commit_addr[AW-1:AL];
    end else if (wr_ok) begin
      base_ce = 1'b1;
      base_d  = wr_data[AW-1:AL];
    end
  end

  // Contents are unspecified after reset; software loads it before enabling.
  always_ff @(posedge clk) begin
    if (base_ce) base_q <= base_d;
  end

  assign list_addr = {base_q, {AL{1'b0}}};
endmodule

// File: rtl/asw_walk_fsm.sv
module asw_walk_fsm
  import asw_pkg::*;
#(
  parameter int AW = 32,
  parameter int AL = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          uframe_start,
  input  logic          uframe_end,
  input  logic          list_empty,
  input  logic [AW-1:0] list_addr,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [AW-1:0] rd_rsp_data,
  output logic          sts,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic          svc_valid,
  output logic [AW-1:0] svc_addr,
  output logic          type_err
);
  walk_st_e      st_q, st_d;
  logic [AW-1:0] cur_q, cur_d;
  logic          sts_q, sts_d;
  logic          start_q, start_d;
  logic          endp_q, endp_d;
  logic          svcv_q, svcv_d;
  logic [AW-1:0] svca_q, svca_d;
  logic          err_q, err_d;

  logic [AW-1:0]          link_ptr;
  logic [LINK_TYPE_W-1:0] link_type;
  logic                   type_ok;
  logic                   end_now;

  assign link_ptr  = {rd_rsp_data[AW-1:AL], {AL{1'b0}}};
  assign link_type = rd_rsp_data[LINK_TYPE_LSB +: LINK_TYPE_W];
  assign type_ok   = (link_type == LINK_TYPE_QH);
  assign end_now   = endp_q || uframe_end;

  always_comb begin
    st_d        = st_q;
    cur_d       = cur_q;
    sts_d       = sts_q;
    start_d     = uframe_start && (st_q == WK_IDLE);
    endp_d      = endp_q;
    svcv_d      = 1'b0;
    svca_d      = svca_q;
    err_d       = 1'b0;
    commit      = 1'b0;
    commit_addr = link_ptr;
    unique case (st_q)
      WK_IDLE: begin
        endp_d = 1'b0;
        if (start_q) begin
          sts_d = cfg_en;
          if (cfg_en && !list_empty) begin
            cur_d = list_addr;
            st_d  = WK_REQ;
          end
        end
      end
      WK_REQ: begin
        if (uframe_end) endp_d = 1'b1;
        if (rd_req_ready) st_d = WK_WAIT;
      end
      WK_WAIT: begin
        if (uframe_end) endp_d = 1'b1;
        if (rd_rsp_valid) begin
          endp_d = 1'b0;
          if (!type_ok) begin
            err_d = 1'b1;
            st_d  = WK_IDLE;
          end else begin
            svcv_d = 1'b1;
            svca_d = cur_q;
            if (end_now) begin
              commit = 1'b1;
              st_d   = WK_IDLE;
            end else if (!cfg_en || list_empty) begin
              commit = 1'b1;
              sts_d  = cfg_en;
              st_d   = WK_IDLE;
            end else begin
              cur_d = link_ptr;
              st_d  = WK_REQ;
            end
          end
        end
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WK_IDLE;
      sts_q   <= 1'b0;
      start_q <= 1'b0;
      endp_q  <= 1'b0;
      svcv_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      sts_q   <= sts_d;
      start_q <= start_d;
      endp_q  <= endp_d;
      svcv_q  <= svcv_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      svca_q <= '0;
    end else begin
      if (st_q != WK_WAIT) cur_q <= cur_d;
      else if (rd_rsp_valid) cur_q <= cur_d;
      if (svcv_d) svca_q <= svca_d;
    end
  end

  assign rd_req_valid = (st_q == WK_REQ);
  assign rd_req_addr  = cur_q;
  assign sts          = sts_q;
  assign svc_valid    = svcv_q;
  assign svc_addr     = svca_q;
  assign type_err     = err_q;
endmodule

// File: rtl/async_sched_walker.sv
module async_sched_walker #(
  parameter int AW          = 32,
  parameter int AL          = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          addr_wr_en,
  input  logic [AW-1:0] addr_wr_data,
  input  logic          uframe_start,
  input  logic          uframe_end,
  input  logic          list_empty,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [AW-1:0] rd_rsp_data,
  output logic          sched_active,
  output logic [AW-1:0] list_addr,
  output logic          svc_valid,
  output logic [AW-1:0] svc_addr,
  output logic          type_err
);
  logic          rst_n_s;
  logic          sts;
  logic          commit;
  logic [AW-1:0] commit_addr;

  asw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  asw_list_reg #(.AW(AW), .AL(AL)) u_list (
    .clk         (clk),
    .wr_en       (addr_wr_en),
    .wr_data     (addr_wr_data),
    .cfg_en      (cfg_en),
    .sts         (sts),
    .commit      (commit),
    .commit_addr (commit_addr),
    .list_addr   (list_addr)
  );

  asw_walk_fsm #(.AW(AW), .AL(AL)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .cfg_en       (cfg_en),
    .uframe_start (uframe_start),
    .uframe_end   (uframe_end),
    .list_empty   (list_empty),
    .list_addr    (list_addr),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .sts          (sts),
    .commit       (commit),
    .commit_addr  (commit_addr),
    .svc_valid    (svc_valid),
    .svc_addr     (svc_addr),
    .type_err     (type_err)
  );

  assign sched_active = sts;
endmodule

// File: rtl/asw_checker.sv
module asw_checker #(
  parameter int AW = 32,
  parameter int AL = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sched_active,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_req_addr,
  input logic          rd_rsp_valid,
  input logic          svc_valid,
  input logic          type_err
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R11

  AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[AL-1:0] == '0)); // R12

  AST_REQ_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> sched_active); // R2

  AST_SVC_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> $past(rd_rsp_valid)); // R4

  AST_ERR_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    type_err |-> $past(rd_rsp_valid)); // R9

  AST_ERR_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    type_err |-> !svc_valid); // R9
endmodule

bind async_sched_walker asw_checker #(.AW(AW), .AL(AL)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sched_active (sched_active),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_valid (rd_rsp_valid),
  .svc_valid    (svc_valid),
  .type_err     (type_err)
);

// File: tb/async_sched_walker_tb.sv
module async_sched_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cfg_en;
  logic        addr_wr_en;
  logic [31:0] addr_wr_data;
  logic        uframe_start;
  logic        uframe_end;
  logic        list_empty;
  logic        rd_req_valid;
  logic        rd_req_ready;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid;
  logic [31:0] rd_rsp_data;
  logic        sched_active;
  logic [31:0] list_addr;
  logic        svc_valid;
  logic [31:0] svc_addr;
  logic        type_err;

  async_sched_walker dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_en       (cfg_en),
    .addr_wr_en   (addr_wr_en),
    .addr_wr_data (addr_wr_data),
    .uframe_start (uframe_start),
    .uframe_end   (uframe_end),
    .list_empty   (list_empty),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .sched_active (sched_active),
    .list_addr    (list_addr),
    .svc_valid    (svc_valid),
    .svc_addr     (svc_addr),
    .type_err     (type_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total;
  int bad;

  // Ring model: 0x1000 -> 0x1040 -> 0x1080 (terminate set) -> 0x10C0 -> 0x1000.
  // 0x2000 holds an isochronous-typed entry (type 00).
  function automatic logic [31:0] link_word(input logic [31:0] a);
    case (a)
      32'h1000: return 32'h1040 | 32'h2;
      32'h1040: return 32'h1080 | 32'h2;
      32'h1080: return 32'h10C0 | 32'h3;
      32'h10C0: return 32'h1000 | 32'h2;
      32'h2000: return 32'h3000;
      default:  return 32'h1000 | 32'h2;
    endcase
  endfunction

  function automatic logic [31:0] next_of(input logic [31:0] a);
    return link_word(a) & ~32'h1F;
  endfunction

  // Memory responder and port monitor, both at the falling edge.
  logic        stall_en;
  logic        acc_pend;
  logic [31:0] acc_addr;
  logic [31:0] svc_log [0:255];
  logic [31:0] req_log [0:255];
  int          svc_cnt;
  int          req_cnt;
  int          err_cnt;

  always @(negedge clk) begin
    logic rdy_n;
    rdy_n = stall_en ? ~rd_req_ready : 1'b1;
    rd_rsp_valid <= acc_pend;
    rd_rsp_data  <= acc_pend ? link_word(acc_addr) : 32'h0;
    acc_pend     <= rd_req_valid && rdy_n;
    acc_addr     <= rd_req_addr;
    rd_req_ready <= rdy_n;
    if (rd_req_valid && rdy_n) begin
      if (req_cnt < 256) req_log[req_cnt] = rd_req_addr;
      req_cnt = req_cnt + 1;
    end
    if (svc_valid) begin
      if (svc_cnt < 256) svc_log[svc_cnt] = svc_addr;
      svc_cnt = svc_cnt + 1;
    end
    if (type_err) err_cnt = err_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) uframe_start = 1'b1;
    @(negedge clk) uframe_start = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk) uframe_end = 1'b1;
    @(negedge clk) uframe_end = 1'b0;
  endtask

  task automatic write_addr(input logic [31:0] a);
    @(negedge clk) begin addr_wr_en = 1'b1; addr_wr_data = a; end
    @(negedge clk) addr_wr_en = 1'b0;
  endtask

  task automatic wait_svc(input int target);
    for (int i = 0; i < 400 && svc_cnt < target; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    check(sched_active == 1'b0, "R1 status", 32'(sched_active), 0);
    check(rd_req_valid == 1'b0, "R1 request", 32'(rd_req_valid), 0);
    check(svc_valid == 1'b0 && type_err == 1'b0, "R1 strobes", 32'({svc_valid, type_err}), 0);
  endtask

  task automatic test_disabled();
    int r0;
    write_addr(32'h1000);
    cycles(1);
    check(list_addr == 32'h1000, "R8 write while clear", list_addr, 32'h1000);
    r0 = req_cnt;
    pulse_start();
    cycles(8);
    check(req_cnt == r0, "R2 no fetch when disabled", req_cnt, r0);
    check(sched_active == 1'b0, "R2 status low", 32'(sched_active), 0);
  endtask

  task automatic test_walk();
    int s0;
    int r0;
    s0 = svc_cnt;
    r0 = req_cnt;
    stall_en = 1'b1;
    @(negedge clk) cfg_en = 1'b1;
    pulse_start();
    wait_svc(s0 + 6);
    pulse_end();
    cycles(8);
    stall_en = 1'b0;
    check(req_log[r0] == 32'h1000, "R3 first fetch", req_log[r0], 32'h1000);
    check(svc_log[s0] == 32'h1000, "R4 first service", svc_log[s0], 32'h1000);
    for (int i = 1; i < 6; i++)
      check(svc_log[s0+i] == next_of(svc_log[s0+i-1]), "R4 R10 ring order",
            svc_log[s0+i], next_of(svc_log[s0+i-1]));
    check(req_cnt - r0 == svc_cnt - s0, "R11 one fetch per service", req_cnt - r0, svc_cnt - s0);
    check(list_addr == next_of(svc_log[svc_cnt-1]), "R5 retained pointer",
          list_addr, next_of(svc_log[svc_cnt-1]));
    check(sched_active == 1'b1, "R7 status set", 32'(sched_active), 1);
  endtask

  task automatic test_resume();
    int s0;
    logic [31:0] exp;
    exp = list_addr;
    s0  = svc_cnt;
    pulse_start();
    wait_svc(s0 + 1);
    @(negedge clk) uframe_end = 1'b1;
    @(negedge clk) uframe_end = 1'b0;
    cycles(8);
    check(svc_log[s0] == exp, "R5 resume entry", svc_log[s0], exp);
    check(list_addr == next_of(svc_log[svc_cnt-1]), "R5 retained again",
          list_addr, next_of(svc_log[svc_cnt-1]));
  endtask

  task automatic test_idle_disable();
    logic [31:0] held;
    int r0;
    held = list_addr;
    @(negedge clk) cfg_en = 1'b0;
    cycles(5);
    check(sched_active == 1'b1, "R7 status waits for fetch point", 32'(sched_active), 1);
    write_addr(32'h2000);
    cycles(1);
    check(list_addr == held, "R8 write ignored while status set", list_addr, held);
    r0 = req_cnt;
    pulse_start();
    cycles(3);
    check(sched_active == 1'b0, "R7 status cleared", 32'(sched_active), 0);
    check(req_cnt == r0, "R7 no fetch after disable", req_cnt, r0);
  endtask

  task automatic test_empty();
    int r0;
    int s0;
    write_addr(32'h1040);
    cycles(1);
    check(list_addr == 32'h1040, "R8 write accepted", list_addr, 32'h1040);
    @(negedge clk) begin cfg_en = 1'b1; list_empty = 1'b1; end
    r0 = req_cnt;
    pulse_start();
    cycles(6);
    check(req_cnt == r0, "R6 empty at start", req_cnt, r0);
    @(negedge clk) list_empty = 1'b0;
    s0 = svc_cnt;
    pulse_start();
    wait_svc(s0 + 3);
    @(negedge clk) list_empty = 1'b1;
    cycles(8);
    s0 = svc_cnt;
    cycles(6);
    check(svc_cnt == s0, "R6 window ended", svc_cnt, s0);
    check(list_addr == next_of(svc_log[svc_cnt-1]), "R6 retained pointer",
          list_addr, next_of(svc_log[svc_cnt-1]));
    @(negedge clk) list_empty = 1'b0;
  endtask

  task automatic test_run_disable();
    int s0;
    s0 = svc_cnt;
    pulse_start();
    wait_svc(s0 + 2);
    @(negedge clk) cfg_en = 1'b0;
    cycles(8);
    s0 = svc_cnt;
    cycles(6);
    check(svc_cnt == s0, "R7 window ended by disable", svc_cnt, s0);
    check(sched_active == 1'b0, "R7 status cleared at fetch", 32'(sched_active), 0);
    check(list_addr == next_of(svc_log[svc_cnt-1]), "R7 retained pointer",
          list_addr, next_of(svc_log[svc_cnt-1]));
  endtask

  task automatic test_type_error();
    int s0;
    int r0;
    int e0;
    write_addr(32'h2000);
    cycles(1);
    check(list_addr == 32'h2000, "R8 write accepted", list_addr, 32'h2000);
    s0 = svc_cnt; r0 = req_cnt; e0 = err_cnt;
    @(negedge clk) cfg_en = 1'b1;
    pulse_start();
    cycles(10);
    check(err_cnt - e0 == 1, "R9 error pulse", err_cnt - e0, 1);
    check(svc_cnt == s0, "R9 no service", svc_cnt, s0);
    check(req_cnt - r0 == 1, "R9 single fetch", req_cnt - r0, 1);
    check(req_log[r0] == 32'h2000, "R12 fetch address", req_log[r0], 32'h2000);
    check(list_addr == 32'h2000, "R9 pointer unchanged", list_addr, 32'h2000);
  endtask

  initial begin
    total = 0; bad = 0;
    svc_cnt = 0; req_cnt = 0; err_cnt = 0;
    stall_en = 1'b0; acc_pend = 1'b0; acc_addr = '0;
    rd_req_ready = 1'b1; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    cfg_en = 1'b0; addr_wr_en = 1'b0; addr_wr_data = '0;
    uframe_start = 1'b0; uframe_end = 1'b0; list_empty = 1'b0;
    rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    fork
      begin
        test_reset();
        test_disabled();
        test_walk();
        test_resume();
        test_idle_disable();
        test_empty();
        test_run_disable();
        test_type_error();
      end
      begin
        cycles(50000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule